// File: doc/BRIEF.md
# Paged Edge-Detect Digital I/O Controller

This block gives a host 48 digital lines, grouped as six 8-bit ports, through an 11-address byte-wide register window. Each line has an open-drain style output. Writing a 1 to a port bit pulls that line low. Writing a 0 releases the line, so no pull-down is applied. Port reads report the synchronised pad level inverted: 1 means the line is low and 0 means it is high.

The first three ports, lines 0 to 23, can also raise interrupts. Each of these lines has a polarity bit, an enable bit and a sticky identification flag. All three sit behind the same three addresses, 0x8 to 0xA, and a page field selects which set those addresses reach.

The page field is held in a small state machine with four states:
- PG_PORTS is the reset state, in which the paged addresses are inert.
- PG_POLARITY routes writes to the polarity registers.
- PG_ENABLE routes writes to the enable registers.
- PG_IDENT routes reads and writes to the identification flags.

The only transition is a write to the selector register at 0x7. That write moves the machine to the state coded in data bits 7:6, from any state including the current one. Reset always returns the machine to PG_PORTS. The same write also loads the six per-port write locks from data bits 5:0.

A summary register at 0x6 reports which of ports 0 to 2 hold flags. One active-high interrupt request follows that summary.

Top module: `paged_edge_dio`

## Requirements
- R1: After reset, no line is pulled low and irq is low. The page state is PG_PORTS, and every polarity, enable and identification bit and every lock is 0.
- R2: A write to address p (0 to 5) loads port p. Data bit b drives pull_low[8p+b]: 1 pulls the line low and 0 releases it.
- R3: Selector bit p (bits 5:0 of a write to 0x7) locks port p, and while it is set, writes to port p leave it unchanged.
- R4: A read of address p returns the inverse of the pad levels of lines 8p to 8p+7, taken after a two-flop synchroniser. A low line reads as 1.
- R5: Only lines 0 to 23 can set identification flags, and only while their enable bit is 1. Ports 3 to 5 and disabled lines never set a flag.
- R6: The polarity bit selects the edge: 1 detects a rising pad edge and 0 a falling one. The flag is visible after the third rising clock edge following the pad change.
- R7: Identification flags are sticky. A write in PG_IDENT to 0x8+k keeps only the flags of port k whose data bit is 1, so writing 0 clears them. An edge detected in the same cycle as a clearing write stays set.
- R8: Bits 7:6 of a write to 0x7 select the page (0 = PG_PORTS, 1 = PG_POLARITY, 2 = PG_ENABLE, 3 = PG_IDENT). At address 0x8+k for k = 0 to 2, page 1 writes polarity and page 2 writes enable for port k, and page 3 reads and writes its flags. Paged addresses read 0 outside PG_IDENT, and 0x7 always reads 0.
- R9: Address 0x6 reads bit k as the OR of the flags of port k, for k = 0 to 2, with bits 7:3 zero. Reading it does not clear anything.
- R10: irq is high exactly when any bit of the summary is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 48 | Pad levels seen on the lines |
| pull_low | output | 48 | 1 pulls the corresponding line low |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
The hardest case to reach is an edge that lands in the same cycle as a clearing write to its identification register.

The bench gets there by counting clock edges through the synchroniser. It changes the external pad drive on a falling clock edge. Two rising edges later, the edge detector is primed. The bench then raises the clearing write so that it meets the flag-setting edge on the third rising edge.

The bench also drives edges from the block's own pull-down outputs through the modelled wired-AND pad. This exercises polarity, enable masking and sticky flags using only register writes.

// File: rtl/pedio_pkg.sv
package pedio_pkg;

    typedef enum logic [1:0] {
        PG_PORTS    = 2'd0,
        PG_POLARITY = 2'd1,
        PG_ENABLE   = 2'd2,
        PG_IDENT    = 2'd3
    } page_t;

    localparam int unsigned SUM_ADDR   = 6;
    localparam int unsigned SEL_ADDR   = 7;
    localparam int unsigned PAGED_BASE = 8;

endpackage

// File: rtl/pedio_sync.sv
module pedio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/pedio_edge_port.sv
module pedio_edge_port #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] wdata,
    input  logic         pol_we,
    input  logic         en_we,
    input  logic         id_we,
    output logic [W-1:0] id_o,
    output logic [W-1:0] en_o
);

    logic [W-1:0] pol_q;
    logic [W-1:0] en_q;
    logic [W-1:0] id_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] hit;
    logic [W-1:0] kept;

    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
        hit  = en_q & ((pol_q & rise) | (~pol_q & fall));
        kept = id_we ? (id_q & wdata) : id_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            en_q   <= '0;
            id_q   <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= level;
            if (pol_we) begin
                pol_q <= wdata;
            end
            if (en_we) begin
                en_q <= wdata;
            end
            id_q <= kept | hit;
        end
    end

    assign id_o = id_q;
    assign en_o = en_q;

endmodule

// File: rtl/paged_edge_dio.sv
module paged_edge_dio
    import pedio_pkg::*;
#(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned BYTE_W       = 8,
    parameter int unsigned N_PORTS      = 6,
    parameter int unsigned N_EDGE_PORTS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [BYTE_W-1:0]           bus_wdata,
    output logic [BYTE_W-1:0]           bus_rdata,
    input  logic [N_PORTS*BYTE_W-1:0]   pad_in,
    output logic [N_PORTS*BYTE_W-1:0]   pull_low,
    output logic                        irq
);

    localparam int unsigned LINES = N_PORTS * BYTE_W;

    page_t page_q;
    page_t page_d;
    logic [N_PORTS-1:0]                    lock_q;
    logic [N_PORTS-1:0][BYTE_W-1:0]        port_q;
    logic [N_PORTS-1:0][BYTE_W-1:0]        line_p;
    logic [LINES-1:0]                      line_s;
    logic [N_EDGE_PORTS-1:0][BYTE_W-1:0]   id_p;
    logic [N_EDGE_PORTS-1:0][BYTE_W-1:0]   en_p;
    logic [N_EDGE_PORTS-1:0]               pend;
    logic [ADDR_W-1:0]                     paged_off;
    logic                                  paged_hit;
    logic                                  sel_wr;
    logic                                  we_pol;
    logic                                  we_en;
    logic                                  we_id;
    logic                                  id_rd;

    pedio_sync #(.W(LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (line_s)
    );

    assign line_p    = line_s;
    assign sel_wr    = bus_wr && (bus_addr == ADDR_W'(SEL_ADDR));
    assign paged_off = bus_addr - ADDR_W'(PAGED_BASE);
    assign paged_hit = (bus_addr >= ADDR_W'(PAGED_BASE)) &&
                       (bus_addr < ADDR_W'(PAGED_BASE + N_EDGE_PORTS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= PG_PORTS;
        end else begin
            page_q <= page_d;
        end
    end

    always_comb begin
        page_d = page_q;
        if (sel_wr) begin
            page_d = page_t'(bus_wdata[BYTE_W-1 -: 2]);
        end
    end

    always_comb begin
        we_pol = 1'b0;
        we_en  = 1'b0;
        we_id  = 1'b0;
        id_rd  = 1'b0;
        unique case (page_q)
            PG_PORTS: begin
            end
            PG_POLARITY: begin
                we_pol = 1'b1;
            end
            PG_ENABLE: begin
                we_en = 1'b1;
            end
            PG_IDENT: begin
                we_id = 1'b1;
                id_rd = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
            port_q <= '0;
        end else begin
            if (sel_wr) begin
                lock_q <= bus_wdata[N_PORTS-1:0];
            end
            for (int p = 0; p < N_PORTS; p++) begin
                if (bus_wr && (bus_addr == ADDR_W'(p)) && !lock_q[p]) begin
                    port_q[p] <= bus_wdata;
                end
            end
        end
    end

    assign pull_low = port_q;

    for (genvar k = 0; k < N_EDGE_PORTS; k++) begin : g_edge
        logic bank_sel;
        assign bank_sel = bus_wr && paged_hit && (paged_off == ADDR_W'(k));

        pedio_edge_port #(.W(BYTE_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .level  (line_p[k]),
            .wdata  (bus_wdata),
            .pol_we (bank_sel && we_pol),
            .en_we  (bank_sel && we_en),
            .id_we  (bank_sel && we_id),
            .id_o   (id_p[k]),
            .en_o   (en_p[k])
        );

        assign pend[k] = |id_p[k];
    end

    assign irq = |pend;

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (bus_addr == ADDR_W'(p)) begin
                bus_rdata = ~line_p[p];
            end
        end
        if (bus_addr == ADDR_W'(SUM_ADDR)) begin
            bus_rdata = BYTE_W'(pend);
        end
        if (paged_hit && id_rd) begin
            for (int k = 0; k < N_EDGE_PORTS; k++) begin
                if (paged_off == ADDR_W'(k)) begin
                    bus_rdata = id_p[k];
                end
            end
        end
    end

endmodule

// File: rtl/paged_edge_dio_chk.sv
module paged_edge_dio_chk #(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned BYTE_W       = 8,
    parameter int unsigned N_PORTS      = 6,
    parameter int unsigned N_EDGE_PORTS = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [ADDR_W-1:0]                 bus_addr,
    input logic                              bus_wr,
    input logic [BYTE_W-1:0]                 bus_rdata,
    input logic [N_PORTS*BYTE_W-1:0]         pull_low,
    input logic                              irq,
    input logic [1:0]                        page_q,
    input logic [N_PORTS-1:0]                lock_q,
    input logic [N_EDGE_PORTS*BYTE_W-1:0]    id_flat,
    input logic [N_EDGE_PORTS*BYTE_W-1:0]    en_flat
);

    logic locked_wr;
    logic paged_rd;
    logic id_clear_wr;

    always_comb begin
        locked_wr = 1'b0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (bus_wr && (bus_addr == ADDR_W'(p)) && lock_q[p]) begin
                locked_wr = 1'b1;
            end
        end
        paged_rd = (bus_addr >= ADDR_W'(8)) &&
                   (bus_addr < ADDR_W'(8 + N_EDGE_PORTS));
        id_clear_wr = bus_wr && paged_rd && (page_q == 2'd3);
    end

    AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        locked_wr |=> $stable(pull_low)); // R3

    AST_NO_FLAG_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_flat == '0 && id_flat == '0) |=> (id_flat == '0)); // R5

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !id_clear_wr |=> ((id_flat & $past(id_flat)) == $past(id_flat))); // R7

    AST_PAGED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (paged_rd && page_q != 2'd3) |-> (bus_rdata == '0)); // R8

    AST_SUMMARY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(6) && !bus_wr && irq) |=> irq); // R9

    AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (id_flat != '0)); // R10

endmodule

bind paged_edge_dio paged_edge_dio_chk #(
    .ADDR_W       (ADDR_W),
    .BYTE_W       (BYTE_W),
    .N_PORTS      (N_PORTS),
    .N_EDGE_PORTS (N_EDGE_PORTS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .pull_low  (pull_low),
    .irq       (irq),
    .page_q    (page_q),
    .lock_q    (lock_q),
    .id_flat   (id_p),
    .en_flat   (en_p)
);

// File: tb/sim_paged_edge_dio.sv
module sim_paged_edge_dio;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [47:0] ext_drv = '1;
    logic [47:0] pad_in;
    logic [47:0] pull_low;
    logic        irq;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    assign pad_in = ~pull_low & ext_drv;

    paged_edge_dio u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pull_low  (pull_low),
        .irq       (irq)
    );

    // {read, req, addr, data}: a read compares data as the expected value
    localparam int NV = 27;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 4'd2, 4'h0, 8'hA5},  // R2 pull bits of port 0
        {1'b1, 4'd4, 4'h0, 8'hA5},  // R4 low lines read as 1
        {1'b0, 4'd2, 4'h5, 8'h3C},  // R2
        {1'b1, 4'd4, 4'h5, 8'h3C},  // R4
        {1'b0, 4'd3, 4'h7, 8'h01},  // R3 lock port 0, page 0
        {1'b0, 4'd3, 4'h0, 8'hFF},  // R3 locked write
        {1'b1, 4'd3, 4'h0, 8'hA5},  // R3 unchanged
        {1'b1, 4'd8, 4'h7, 8'h00},  // R8 selector reads 0
        {1'b0, 4'd8, 4'h7, 8'h40},  // R8 polarity page, unlock
        {1'b1, 4'd8, 4'h8, 8'h00},  // R8 paged read is 0
        {1'b0, 4'd6, 4'h8, 8'hFF},  // R6 port 0 rising
        {1'b0, 4'd8, 4'h7, 8'h80},  // R8 enable page
        {1'b0, 4'd5, 4'h8, 8'h0F},  // R5 enable bits 3:0
        {1'b1, 4'd8, 4'h9, 8'h00},  // R8
        {1'b0, 4'd8, 4'h7, 8'hC0},  // R8 ident page
        {1'b1, 4'd5, 4'h8, 8'h00},  // R5 no flags yet
        {1'b1, 4'd9, 4'h6, 8'h00},  // R9
        {1'b0, 4'd2, 4'h0, 8'h00},  // R2 release: rising on 0,2,5,7
        {1'b1, 4'd4, 4'h0, 8'h00},  // R4
        {1'b1, 4'd6, 4'h8, 8'h05},  // R6 only enabled rising lines
        {1'b1, 4'd9, 4'h6, 8'h01},  // R9
        {1'b1, 4'd9, 4'h6, 8'h01},  // R9 read does not clear
        {1'b0, 4'd7, 4'h8, 8'h04},  // R7 keep bit 2 only
        {1'b1, 4'd7, 4'h8, 8'h04},  // R7
        {1'b0, 4'd7, 4'h8, 8'h00},  // R7 clear
        {1'b1, 4'd7, 4'h8, 8'h00},  // R7
        {1'b1, 4'd9, 4'h6, 8'h00}   // R9
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        check("R1 pull_low after reset", 64'(pull_low), 64'h0);
        check("R1 irq after reset", 64'(irq), 64'h0);
        rst_n = 1'b1;
        bus_read(4'h6, rd);
        check("R1 summary after reset", 64'(rd), 64'h0);
        bus_read(4'h0, rd);
        check("R1 port 0 after reset", 64'(rd), 64'h0);

        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            if (v[16]) begin
                bus_read(v[11:8], rd);
                check($sformatf("R%0d table step %0d", v[15:12], i), 64'(rd), 64'(v[7:0]));
            end else begin
                bus_write(v[11:8], v[7:0]);
            end
        end

        // R4: external driver pulls a line low
        ext_drv[40] = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(4'h5, rd);
        check("R4 external low on port 5", 64'(rd), 64'h3D);
        ext_drv[40] = 1'b1;

        // R6: falling polarity on port 1 bit 0, timed through the synchroniser
        bus_write(4'h7, 8'h40);
        bus_write(4'h9, 8'h00);
        bus_write(4'h7, 8'h80);
        bus_write(4'h9, 8'h01);
        bus_write(4'h7, 8'hC0);
        @(negedge clk);
        ext_drv[8] = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 flag not yet set after two edges", 64'(irq), 64'h0);
        @(negedge clk);
        check("R10 irq after third edge", 64'(irq), 64'h1);
        bus_read(4'h6, rd);
        check("R9 summary port 1", 64'(rd), 64'h02);
        bus_read(4'h9, rd);
        check("R6 falling flag", 64'(rd), 64'h01);

        // R5: disabled and non-interrupt lines
        ext_drv[9]  = 1'b0;
        ext_drv[16] = 1'b0;
        ext_drv[24] = 1'b0;
        ext_drv[47] = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(4'h9, rd);
        check("R5 disabled line in port 1", 64'(rd), 64'h01);
        bus_read(4'h6, rd);
        check("R5 ports 2..5 raise nothing", 64'(rd), 64'h02);
        ext_drv[9]  = 1'b1;
        ext_drv[16] = 1'b1;
        ext_drv[24] = 1'b1;
        ext_drv[47] = 1'b1;

        // R7 clear then R6 wrong polarity ignored
        bus_write(4'h9, 8'h00);
        check("R7 irq after clear", 64'(irq), 64'h0);
        ext_drv[8] = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(4'h9, rd);
        check("R6 rising ignored with falling polarity", 64'(rd), 64'h00);

        // R7: edge in the same cycle as a clearing write survives
        @(negedge clk);
        ext_drv[8] = 1'b0;
        repeat (2) @(negedge clk);
        bus_addr  = 4'h9;
        bus_wdata = 8'h00;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #2;
        check("R7 simultaneous edge and clear", 64'(bus_rdata), 64'h01);
        check("R10 irq stays high", 64'(irq), 64'h1);

        // R1: reset in the middle of a run
        @(negedge clk);
        bus_write(4'h1, 8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pull_low cleared by reset", 64'(pull_low), 64'h0);
        check("R1 irq cleared by reset", 64'(irq), 64'h0);
        rst_n = 1'b1;
        bus_read(4'h9, rd);
        check("R1 page back to ports", 64'(rd), 64'h00);
        bus_write(4'h7, 8'hC0);
        bus_read(4'h9, rd);
        check("R1 flags zero after reset", 64'(rd), 64'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule